// File: doc/BRIEF.md
# Programmable clock source divider

This block derives a slower clock from one of four parent clocks. A single 32-bit control word holds three fields. The first picks the parent. The second sets a power-of-two prescale step. The third sets an integer division that follows the prescale. The output period is therefore `N = (d+1) * 2^s` periods of the chosen parent. The control word is written and read over a plain one-cycle bus port. Software changes one field with a read-modify-write of the whole word.

Everything runs on one reference clock. The parent clocks are treated as level signals that are already synchronous to that clock. The block registers them, picks one and detects its rising edges. It then counts those edges through the prescale and integer stages. It drives a divided clock and a one-reference-cycle pulse that marks the start of each output period.

New prescale and divide values are held back until the current output period ends. A new parent choice is applied only in a cycle where the old parent and the new one are both low.

The parent selector has two states:
- `SW_RUN`: the active parent matches the requested one. It moves to `SW_WAIT` when the request differs.
- `SW_WAIT`: it returns to `SW_RUN` when the request is withdrawn. It also returns to `SW_RUN` after switching, in a cycle where both parents are low.

The divider has three states:
- `DV_PASS`: the total division is 1 and the output follows the parent.
- `DV_HIGH`: the output is high.
- `DV_LOW`: the output is low.

A period boundary moves the divider into `DV_PASS` or `DV_HIGH`, depending on the newly loaded division. A parent edge that brings the position within the period to half of N moves `DV_HIGH` to `DV_LOW`.

Top module: `pclk_divider`

## Requirements
- R1: While reset is asserted and right after it, the control word reads 0, the divided clock is low and the period pulse is low.
- R2: The parent select field is at bits 17:16, the prescale field at bits 5:4 and the integer divide field at bits 12:8. All other bits read as 0 and ignore writes, so a read returns the last written word ANDed with 0x0003_1F30. A read-modify-write that changes one field leaves the other fields as read.
- R3: The divided clock has a period of (d+1)*2^s periods of the selected parent, with s in 0..3 and d in 0..31.
- R4: Select code k (0..3) makes input src_clk_i[k] the parent.
- R5: With s=0 and d=0 the divided clock follows the parent, with the same high time and period.
- R6: For a total division N of 2 or more, the divided clock is high for floor(N/2) parent periods of each output period. When N is even, this gives an exact half duty.
- R7: tick_o is high for exactly one reference cycle per output period, in the cycle in which the divided clock rises.
- R8: A new prescale or divide value written in the middle of an output period does not shorten or lengthen that period. It applies from the next period boundary.
- R9: The active parent changes only in a cycle where both the old and the new parent were sampled low, and the divided clock is never raised by the switch itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the control word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current control word, unused bits zero |
| src_clk_i | input | 4 | The four parent clocks, as levels synchronous to clk |
| clk_div_o | output | 1 | Divided clock |
| tick_o | output | 1 | One-cycle pulse at the start of each output period |

## Verification
The assertions assume that every parent is a level synchronous to the reference clock, and that each high phase and each low phase lasts at least one reference cycle. Without that, edges would be missed and the edge-count checks would not apply. The bench keeps to this by toggling the parents from falling-edge counters, with half periods of 1 to 4 reference cycles. Register writes may arrive at any moment relative to the parents. Random words also set the unused bits, so they exercise the read-back masking alongside the divide sweep.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
    localparam int REG_W   = 32;
    localparam int NSRC    = 4;
    localparam int SEL_W   = $clog2(NSRC);
    localparam int SEL_LSB = 16;
    localparam int PRE_W   = 2;
    localparam int PRE_LSB = 4;
    localparam int DIV_W   = 5;
    localparam int DIV_LSB = 8;
    // prescale counter must reach 2^(2^PRE_W - 1) - 1
    localparam int PCNT_W  = (1 << PRE_W) - 1;
    localparam int TOT_W   = DIV_W + PCNT_W + 1;

    localparam logic [REG_W-1:0] FIELD_MASK = REG_W'(
        (((1 << SEL_W) - 1) << SEL_LSB) |
        (((1 << PRE_W) - 1) << PRE_LSB) |
        (((1 << DIV_W) - 1) << DIV_LSB));

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
    } cfg_t;

    typedef enum logic {SW_RUN, SW_WAIT} sw_state_e;
    typedef enum logic [1:0] {DV_PASS, DV_HIGH, DV_LOW} dv_state_e;
endpackage

// File: rtl/pclk_ctrl_reg.sv
module pclk_ctrl_reg
    import pclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output cfg_t             cfg_o
);
    cfg_t cfg_q;
    logic unused_spare;

    assign unused_spare = ^(wdata & ~FIELD_MASK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q.sel <= wdata[SEL_LSB +: SEL_W];
            cfg_q.pre <= wdata[PRE_LSB +: PRE_W];
            cfg_q.div <= wdata[DIV_LSB +: DIV_W];
        end
    end

    always_comb begin
        rdata = '0;
        rdata[SEL_LSB +: SEL_W] = cfg_q.sel;
        rdata[PRE_LSB +: PRE_W] = cfg_q.pre;
        rdata[DIV_LSB +: DIV_W] = cfg_q.div;
    end

    assign cfg_o = cfg_q;

    assert_spare_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~FIELD_MASK) == '0);
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rdata == ($past(wdata) & FIELD_MASK));
    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata));
endmodule

// File: rtl/pclk_src_sel.sv
module pclk_src_sel
    import pclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic [SEL_W-1:0] sel_req,
    output logic             lvl_o,
    output logic             rise_o
);
    sw_state_e        state_q, state_d;
    logic [NSRC-1:0]  src_q;
    logic [SEL_W-1:0] act_q;
    logic             lvl_prev_q;
    logic             lvl_cur, lvl_req, both_low;

    assign lvl_cur  = src_q[act_q];
    assign lvl_req  = src_q[sel_req];
    assign both_low = !lvl_cur && !lvl_req;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SW_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_RUN:  state_d = (sel_req != act_q) ? SW_WAIT : SW_RUN;
            SW_WAIT: state_d = (sel_req == act_q || both_low) ? SW_RUN : SW_WAIT;
            default: state_d = SW_RUN;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q      <= '0;
            act_q      <= '0;
            lvl_prev_q <= 1'b0;
        end else begin
            src_q      <= src_i;
            lvl_prev_q <= lvl_cur;
            if (state_q == SW_WAIT && sel_req != act_q && both_low)
                act_q <= sel_req;
        end
    end

    assign lvl_o  = lvl_cur;
    assign rise_o = lvl_cur && !lvl_prev_q;

    assert_switch_only_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !both_low |=> $stable(act_q));
    assert_switch_no_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |-> !lvl_prev_q);
endmodule

// File: rtl/pclk_div_core.sv
module pclk_div_core
    import pclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre_req,
    input  logic [DIV_W-1:0] div_req,
    input  logic             lvl_i,
    input  logic             rise_i,
    output logic             clk_o,
    output logic             tick_o
);
    dv_state_e         state_q, state_d;
    logic [PRE_W-1:0]  pre_a;
    logic [DIV_W-1:0]  div_a;
    logic [PCNT_W-1:0] pre_cnt, pre_nxt, pre_lim;
    logic [DIV_W-1:0]  div_cnt, div_nxt;
    logic [TOT_W-1:0]  ntot, half, pos_nxt;
    logic              last, wrap, lvl_q, tick_q;
    dv_state_e         after_wrap;

    always_comb begin
        pre_lim = '0;
        for (int i = 0; i < PCNT_W; i++)
            pre_lim[i] = (i < int'(pre_a));
    end

    assign ntot = (TOT_W'(div_a) + TOT_W'(1)) << pre_a;
    assign half = ntot >> 1;
    assign last = (pre_cnt == pre_lim) && (div_cnt == div_a);
    assign wrap = rise_i && last;
    assign after_wrap = (pre_req == '0 && div_req == '0) ? DV_PASS : DV_HIGH;

    always_comb begin
        if (pre_cnt == pre_lim) begin
            pre_nxt = '0;
            div_nxt = div_cnt + 1'b1;
        end else begin
            pre_nxt = pre_cnt + 1'b1;
            div_nxt = div_cnt;
        end
        pos_nxt = (TOT_W'(div_nxt) << pre_a) | TOT_W'(pre_nxt);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DV_PASS;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DV_PASS: if (wrap) state_d = after_wrap;
            DV_HIGH: begin
                if (wrap) state_d = after_wrap;
                else if (rise_i && pos_nxt >= half) state_d = DV_LOW;
            end
            DV_LOW:  if (wrap) state_d = after_wrap;
            default: state_d = DV_PASS;
        endcase
    end

    // outputs, counters and active settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_a   <= '0;
            div_a   <= '0;
            pre_cnt <= '0;
            div_cnt <= '0;
            lvl_q   <= 1'b0;
            tick_q  <= 1'b0;
        end else begin
            lvl_q  <= lvl_i;
            tick_q <= wrap;
            if (wrap) begin
                pre_a   <= pre_req;
                div_a   <= div_req;
                pre_cnt <= '0;
                div_cnt <= '0;
            end else if (rise_i) begin
                pre_cnt <= pre_nxt;
                div_cnt <= div_nxt;
            end
        end
    end

    assign clk_o  = (state_q == DV_PASS) ? lvl_q : (state_q == DV_HIGH);
    assign tick_o = tick_q;

    assert_counts_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= pre_lim && div_cnt <= div_a);
    assert_reload_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_a != $past(pre_a) || div_a != $past(div_a)) |-> tick_o);
    assert_pulse_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (clk_o && !$past(clk_o)));
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/pclk_divider.sv
module pclk_divider
    import pclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]  src_clk_i,
    output logic             clk_div_o,
    output logic             tick_o
);
    cfg_t cfg;
    logic sel_lvl, sel_rise;

    pclk_ctrl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg_o (cfg)
    );

    pclk_src_sel u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_clk_i),
        .sel_req (cfg.sel),
        .lvl_o   (sel_lvl),
        .rise_o  (sel_rise)
    );

    pclk_div_core u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_req (cfg.pre),
        .div_req (cfg.div),
        .lvl_i   (sel_lvl),
        .rise_i  (sel_rise),
        .clk_o   (clk_div_o),
        .tick_o  (tick_o)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (bus_rdata == '0 && !clk_div_o && !tick_o));
endmodule

// File: tb/pclk_divider_tb_top.sv
module pclk_divider_tb_top;
    localparam logic [31:0] MASK = 32'h0003_1F30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src = '0;
    logic        clk_div_o, tick_o;
    int          scnt [4] = '{0, 0, 0, 0};
    int          total = 0, bad = 0;

    always #5 clk = ~clk;

    // parent k: half period k+1 reference cycles
    always @(negedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (scnt[k] == k) begin
                scnt[k] <= 0;
                src[k]  <= ~src[k];
            end else begin
                scnt[k] <= scnt[k] + 1;
            end
        end
    end

    pclk_divider dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_clk_i (src),
        .clk_div_o (clk_div_o),
        .tick_o    (tick_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_per(input int sel, input int s, input int d);
        return ((d + 1) << s) * 2 * (sel + 1);
    endfunction

    function automatic int exp_hi(input int sel, input int s, input int d);
        int n = (d + 1) << s;
        return (n == 1) ? (sel + 1) : (n / 2) * 2 * (sel + 1);
    endfunction

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b1;
        bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wait_rise();
        bit prev = 1'b1;
        bit c;
        forever begin
            @(negedge clk);
            c = clk_div_o;
            if (!prev && c) break;
            prev = c;
        end
    endtask

    task automatic measure(output int per, output int hi, output int pul);
        bit prev, c;
        wait_rise();
        per = 1; hi = 1; pul = tick_o ? 1 : 0; prev = 1'b1;
        forever begin
            @(negedge clk);
            c = clk_div_o;
            if (!prev && c) break;
            per++;
            if (c) hi++;
            if (tick_o) pul++;
            prev = c;
        end
    endtask

    task automatic wait_pulses(input int n);
        repeat (n) begin
            do @(negedge clk); while (!tick_o);
        end
    endtask

    task automatic run_cfg(input int sel, input int s, input int d,
                           input logic [31:0] junk, input string tag);
        logic [31:0] v;
        int per, hi, pul, n;
        v = junk & ~MASK;
        v[17:16] = 2'(sel);
        v[5:4]   = 2'(s);
        v[12:8]  = 5'(d);
        wr(v);
        check(bus_rdata == (v & MASK), {"R2 readback ", tag}, int'(bus_rdata), int'(v & MASK));
        repeat (40) @(negedge clk);
        wait_pulses(2);
        measure(per, hi, pul);
        n = (d + 1) << s;
        check(per == exp_per(sel, s, d), {"R3 R4 period ", tag}, per, exp_per(sel, s, d));
        check(hi == exp_hi(sel, s, d), (n == 1) ? {"R5 high ", tag} : {"R6 high ", tag},
              hi, exp_hi(sel, s, d));
        check(pul == 1, {"R7 pulses ", tag}, pul, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rb;
        int per, hi, pul, i;
        bit prev, c;
        void'($urandom(32'd7741));

        repeat (3) @(negedge clk);
        check(bus_rdata == 0, "R1 reg in reset", int'(bus_rdata), 0);
        check(clk_div_o == 0, "R1 clk in reset", int'(clk_div_o), 0);
        check(tick_o == 0, "R1 tick in reset", int'(tick_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_rdata == 0, "R1 reg after reset", int'(bus_rdata), 0);

        // unused bits
        wr(32'hFFFF_FFFF);
        check(bus_rdata == MASK, "R2 spare bits", int'(bus_rdata), int'(MASK));
        wr(32'h0);
        check(bus_rdata == 0, "R2 clear", int'(bus_rdata), 0);

        // each parent with division 1
        for (int k = 0; k < 4; k++) run_cfg(k, 0, 0, 32'h0, "R4 pass");

        // prescale sweep
        for (int s = 0; s < 4; s++) run_cfg(1, s, 2, 32'h0, "R3 sweep");
        run_cfg(0, 0, 4, 32'h0, "R6 odd");
        run_cfg(2, 0, 1, 32'h0, "R6 two");
        run_cfg(0, 3, 31, 32'h0, "R3 max");

        // read-modify-write of one field
        run_cfg(0, 1, 2, 32'h0, "R8 base");
        rb = bus_rdata;
        rb[17:16] = 2'd3;
        wr(rb);
        check(bus_rdata[12:8] == 5'd2 && bus_rdata[5:4] == 2'd1, "R2 rmw fields",
              int'(bus_rdata), int'(rb));
        rb = bus_rdata;
        rb[17:16] = 2'd0;
        wr(rb);
        repeat (40) @(negedge clk);
        wait_pulses(2);

        // mid-period change must not alter the running period
        wait_rise();
        per = 1; prev = 1'b1; i = 0;
        forever begin
            @(negedge clk);
            i++;
            if (i == 3) begin
                bus_we = 1'b1;
                bus_wdata = 32'h0;
            end else begin
                bus_we = 1'b0;
            end
            c = clk_div_o;
            if (!prev && c) break;
            per++;
            prev = c;
        end
        check(per == exp_per(0, 1, 2), "R8 running period", per, exp_per(0, 1, 2));
        measure(per, hi, pul);
        check(per == exp_per(0, 0, 0), "R8 next period", per, exp_per(0, 0, 0));

        // random settings with junk in unused bits
        for (int r = 0; r < 8; r++) begin
            run_cfg($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 31),
                    $urandom, "R3 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule